// File: doc/BRIEF.md
# Halfword Split and Merge Datapath

This block lets a 32-bit internal data word cross a 16-bit external bus as two halfwords. The pace is set by outside logic through two asynchronous control pins. On a write, a halfword-select pin decides which half of the internal word is driven onto the external bus. The bus is driven only while a write cycle is active, and an output enable says when.

On a read, a falling edge on an active-low capture pin stores the value then present on the external bus as the upper halfword. Outside logic then places the second halfword on the bus and ends the cycle. When the cycle completes, the block presents the assembled word. Its upper half comes from the captured halfword if a capture happened during the cycle. Otherwise it comes from a separate 16-bit input fed by external transceivers.

Both control pins are synchronized with a chain of flip-flops before use. The capture edge is detected on the synchronized signal. A cycle-start pulse clears the record of a capture.

Top module: `halfword_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bd_oe, bd_out, rd_valid and rd_word are all zero.
- R2: With wr_active high and hsel_async low (after synchronization), bd_out carries wr_word[31:16].
- R3: With wr_active high and hsel_async high (after synchronization), bd_out carries wr_word[15:0].
- R4: bd_oe equals wr_active delayed by one clock, and bd_out is zero whenever bd_oe is low.
- R5: A falling edge on hcap_n_async, once synchronized, stores bd_in as the upper halfword of the read word. A rising edge or a steady level stores nothing.
- R6: rd_valid is high for exactly the one clock after a cycle in which cyc_done is high. rd_word[15:0] then equals the bd_in value sampled in that cycle.
- R7: If no capture happened since the last cyc_start, rd_word[31:16] equals xcvr_hi as sampled with cyc_done. If a capture did happen, it equals the captured halfword.
- R8: cyc_start clears the capture record, so an earlier cycle's capture never supplies the upper half of a later cycle's word.
- R9: A change on hsel_async reaches bd_out on the third rising clock edge after it is presented, and not before.
- R10: A capture edge detected in the same clock as cyc_start belongs to the new cycle and is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse opening a new I/O cycle |
| cyc_done | input | 1 | One-clock pulse closing a read cycle |
| wr_active | input | 1 | A write cycle is in progress |
| wr_word | input | 32 | Internal word to be written |
| hsel_async | input | 1 | Asynchronous halfword select: 0 upper, 1 lower |
| hcap_n_async | input | 1 | Asynchronous active-low capture; the falling edge captures |
| bd_in | input | 16 | External bus value as seen on input |
| xcvr_hi | input | 16 | Upper halfword from the external transceivers |
| bd_out | output | 16 | Value driven onto the external bus |
| bd_oe | output | 1 | External bus output enable |
| rd_word | output | 32 | Assembled read word |
| rd_valid | output | 1 | rd_word was updated this clock |

## Verification
The hardest situation to reach is a capture edge that lands in the very clock in which cyc_start clears the capture record. The bench has to place the capture pin's fall exactly two edges before the start pulse is sampled, so that the synchronized fall and the start coincide. A second awkward case is a rising capture pin inside a cycle whose preceding fall was wiped by cyc_start. It is produced by lowering the pin before the cycle opens and releasing it with a new bus value afterwards. Synchronizer latency is checked by sampling bd_out after two and after three edges following a select change.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
    typedef enum logic {
        SEL_UPPER = 1'b0,
        SEL_LOWER = 1'b1
    } half_sel_e;

    typedef enum logic {
        SRC_XCVR  = 1'b0,
        SRC_LATCH = 1'b1
    } hi_src_e;
endpackage

// File: rtl/hwb_sync.sv
module hwb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= d_async;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hwb_wr_mux.sv
module hwb_wr_mux
    import hwb_pkg::*;
#(
    parameter int HW = 16,
    localparam int WW = 2 * HW
) (
    input  logic [WW-1:0] word,
    input  half_sel_e     sel,
    input  logic          en,
    output logic [HW-1:0] half
);
    always_comb begin
        half = '0;
        if (en) begin
            half = (sel == SEL_LOWER) ? word[HW-1:0] : word[WW-1:HW];
        end
    end
endmodule

// File: rtl/hwb_rd_merge.sv
module hwb_rd_merge
    import hwb_pkg::*;
#(
    parameter int HW = 16,
    localparam int WW = 2 * HW
) (
    input  hi_src_e       src,
    input  logic [HW-1:0] latched_hi,
    input  logic [HW-1:0] xcvr_hi,
    input  logic [HW-1:0] lower,
    output logic [WW-1:0] word
);
    always_comb begin
        word = {(src == SRC_LATCH) ? latched_hi : xcvr_hi, lower};
    end
endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
    import hwb_pkg::*;
#(
    parameter int HW          = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          cyc_done,
    input  logic          wr_active,
    input  logic [WW-1:0] wr_word,
    input  logic          hsel_async,
    input  logic          hcap_n_async,
    input  logic [HW-1:0] bd_in,
    input  logic [HW-1:0] xcvr_hi,
    output logic [HW-1:0] bd_out,
    output logic          bd_oe,
    output logic [WW-1:0] rd_word,
    output logic          rd_valid
);
    typedef struct packed {
        logic [HW-1:0] bd_out;
        logic          bd_oe;
        logic          cap_prev;
        logic [HW-1:0] hi_hold;
        logic          captured;
        logic [WW-1:0] rd_word;
        logic          rd_valid;
    } state_t;

    localparam state_t RST_STATE = '{
        bd_out:   '0,
        bd_oe:    1'b0,
        cap_prev: 1'b1,
        hi_hold:  '0,
        captured: 1'b0,
        rd_word:  '0,
        rd_valid: 1'b0
    };

    state_t s_d, s_q;

    logic          sel_s;
    logic          cap_s;
    logic          cap_fall;
    logic [HW-1:0] mux_half;
    logic [WW-1:0] merged;
    hi_src_e       hi_src;

    hwb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hsel_async),
        .q_sync  (sel_s)
    );

    hwb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cap_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hcap_n_async),
        .q_sync  (cap_s)
    );

    hwb_wr_mux #(.HW(HW)) u_wr_mux (
        .word (wr_word),
        .sel  (half_sel_e'(sel_s)),
        .en   (wr_active),
        .half (mux_half)
    );

    assign hi_src = s_q.captured ? SRC_LATCH : SRC_XCVR;

    hwb_rd_merge #(.HW(HW)) u_rd_merge (
        .src        (hi_src),
        .latched_hi (s_q.hi_hold),
        .xcvr_hi    (xcvr_hi),
        .lower      (bd_in),
        .word       (merged)
    );

    assign cap_fall = s_q.cap_prev & ~cap_s;

    always_comb begin
        s_d          = s_q;
        s_d.cap_prev = cap_s;
        s_d.bd_oe    = wr_active;
        s_d.bd_out   = mux_half;
        s_d.rd_valid = cyc_done;
        if (cyc_start) begin
            s_d.captured = 1'b0;
        end
        if (cap_fall) begin
            s_d.hi_hold  = bd_in;
            s_d.captured = 1'b1;
        end
        if (cyc_done) begin
            s_d.rd_word = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign bd_out   = s_q.bd_out;
    assign bd_oe    = s_q.bd_oe;
    assign rd_word  = s_q.rd_word;
    assign rd_valid = s_q.rd_valid;
endmodule

// File: rtl/halfword_bridge_chk.sv
module halfword_bridge_chk #(
    parameter int HW = 16,
    localparam int WW = 2 * HW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_start,
    input logic          cyc_done,
    input logic          wr_active,
    input logic [WW-1:0] wr_word,
    input logic [HW-1:0] bd_in,
    input logic [HW-1:0] bd_out,
    input logic          bd_oe,
    input logic          rd_valid,
    input logic [WW-1:0] rd_word,
    input logic          sel_s,
    input logic          cap_fall,
    input logic          captured
);
    assert_oe_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_active |=> bd_oe);
    assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_active |=> !bd_oe);
    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bd_oe |-> (bd_out == '0));
    assert_upper_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && !sel_s) |=> (bd_out == $past(wr_word[WW-1:HW])));
    assert_lower_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && sel_s) |=> (bd_out == $past(wr_word[HW-1:0])));
    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> rd_valid);
    assert_valid_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |=> !rd_valid);
    assert_lower_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (rd_word[HW-1:0] == $past(bd_in)));
    assert_capture_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fall |=> captured);
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !cap_fall) |=> !captured);
endmodule

bind halfword_bridge halfword_bridge_chk #(.HW(HW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_done  (cyc_done),
    .wr_active (wr_active),
    .wr_word   (wr_word),
    .bd_in     (bd_in),
    .bd_out    (bd_out),
    .bd_oe     (bd_oe),
    .rd_valid  (rd_valid),
    .rd_word   (rd_word),
    .sel_s     (sel_s),
    .cap_fall  (cap_fall),
    .captured  (s_q.captured)
);

// File: tb/halfword_bridge_test.sv
module halfword_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic        cyc_done = 1'b0;
    logic        wr_active = 1'b0;
    logic [31:0] wr_word = '0;
    logic        hsel_async = 1'b1;
    logic        hcap_n_async = 1'b1;
    logic [15:0] bd_in = '0;
    logic [15:0] xcvr_hi = '0;
    logic [15:0] bd_out;
    logic        bd_oe;
    logic [31:0] rd_word;
    logic        rd_valid;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    halfword_bridge uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .cyc_done     (cyc_done),
        .wr_active    (wr_active),
        .wr_word      (wr_word),
        .hsel_async   (hsel_async),
        .hcap_n_async (hcap_n_async),
        .bd_in        (bd_in),
        .xcvr_hi      (xcvr_hi),
        .bd_out       (bd_out),
        .bd_oe        (bd_oe),
        .rd_word      (rd_word),
        .rd_valid     (rd_valid)
    );

    typedef struct packed {
        logic        is_rd;
        logic        ctl;
        logic [31:0] data;
        logic [15:0] xcvr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'hA1B2C3D4, 16'h0000, 32'h0000C3D4},
        '{1'b0, 1'b0, 32'hA1B2C3D4, 16'h0000, 32'h0000A1B2},
        '{1'b0, 1'b0, 32'hFFFF0000, 16'h0000, 32'h0000FFFF},
        '{1'b0, 1'b1, 32'hFFFF0000, 16'h0000, 32'h00000000},
        '{1'b1, 1'b1, 32'h12345678, 16'h9999, 32'h12345678},
        '{1'b1, 1'b0, 32'h1234ABCD, 16'h9999, 32'h9999ABCD},
        '{1'b1, 1'b1, 32'h80010002, 16'h0000, 32'h80010002},
        '{1'b1, 1'b0, 32'h0000FFFF, 16'h7E7E, 32'h7E7EFFFF}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        cyc_start = 1'b1;
        step(1);
        cyc_start = 1'b0;
    endtask

    task automatic finish_read(input logic [31:0] exp, input string req);
        cyc_done = 1'b1;
        step(1);
        cyc_done = 1'b0;
        check("R6 valid", {31'd0, rd_valid}, 32'd1);
        check(req, rd_word, exp);
        step(1);
        check("R6 one-shot", {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1 oe", {31'd0, bd_oe}, 32'd0);
        check("R1 bd", {16'd0, bd_out}, 32'd0);
        check("R1 valid", {31'd0, rd_valid}, 32'd0);
        check("R1 word", rd_word, 32'd0);
        rst_n = 1'b1;
        step(1);
        check("R1 after", {15'd0, bd_oe, bd_out}, 32'd0);

        // vector table: writes (R2, R3) and reads (R5, R7, R8)
        for (int v = 0; v < NV; v++) begin
            if (!VECS[v].is_rd) begin
                wr_active = 1'b1;
                wr_word = VECS[v].data;
                hsel_async = VECS[v].ctl;
                step(4);
                check(VECS[v].ctl ? "R3 lower" : "R2 upper", {16'd0, bd_out}, VECS[v].exp);
                check("R4 oe high", {31'd0, bd_oe}, 32'd1);
            end else begin
                wr_active = 1'b0;
                xcvr_hi = VECS[v].xcvr;
                pulse_start();
                bd_in = VECS[v].data[31:16];
                if (VECS[v].ctl) hcap_n_async = 1'b0;
                step(4);
                hcap_n_async = 1'b1;
                bd_in = VECS[v].data[15:0];
                step(4);
                finish_read(VECS[v].exp, VECS[v].ctl ? "R5 capture" : "R7 R8 xcvr");
            end
        end

        // R4: leaving write drops oe and quiets the bus one clock later
        wr_active = 1'b1;
        wr_word = 32'hDEAD5A5A;
        hsel_async = 1'b1;
        step(4);
        wr_active = 1'b0;
        step(1);
        check("R4 oe low", {31'd0, bd_oe}, 32'd0);
        check("R4 bd quiet", {16'd0, bd_out}, 32'd0);

        // R9: select change latency
        wr_active = 1'b1;
        wr_word = 32'hAAAA5555;
        hsel_async = 1'b1;
        step(4);
        hsel_async = 1'b0;
        step(2);
        check("R9 early", {16'd0, bd_out}, 32'h5555);
        step(1);
        check("R9 third edge", {16'd0, bd_out}, 32'hAAAA);
        wr_active = 1'b0;

        // R5: a rising capture pin after start clears the record stores nothing
        xcvr_hi = 16'h3C3C;
        bd_in = 16'h1111;
        hcap_n_async = 1'b0;
        step(4);
        pulse_start();
        bd_in = 16'h2222;
        hcap_n_async = 1'b1;
        step(4);
        bd_in = 16'h0077;
        finish_read(32'h3C3C0077, "R5 rise ignored");

        // R10: capture detected in the same clock as cyc_start is kept
        xcvr_hi = 16'h1111;
        bd_in = 16'hBEEF;
        hcap_n_async = 1'b0;
        step(2);
        pulse_start();
        step(2);
        hcap_n_async = 1'b1;
        bd_in = 16'h0042;
        step(4);
        finish_read(32'hBEEF0042, "R10 same-clock capture");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule